// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block builds a 20-bit physical address from a 16-bit segment and a 16-bit offset. It uses a single 16-bit adder for the whole computation. The adder adds the segment to the offset with the offset's four low bits dropped. The sum, with four zero bits placed below it, forms the upper part of the address. The offset's low nibble is kept apart and comes out through its own port. Combining the two ports gives the full address, wrapping modulo 2^20.

The block is driven by one-cycle state strobes from the bus sequencer:

- **Start strobe:** loads the adder operands and the index register.
- **Address strobe:** publishes the address.
- **Update-setup strobe:** reuses the idle adder to add a small signed constant (−3 to +2) to the index register.
- **Update-commit strobe:** writes the adder result back to the index register, wrapping modulo 2^16. A stack pop, for example, adds +2 after the access.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is held, and until the first strobe after it, `ad_hi_o`, `ad_lo_o` and `idx_o` are all zero.
- R2: After a start strobe followed by an address strobe, `ad_hi_o` equals ((seg + (ofs >> 4)) mod 2^16) shifted left by four. Here seg and ofs are the inputs sampled on the start strobe.
- R3: Bits 3:0 of `ad_hi_o` are always zero.
- R4: After the same pair of strobes, `ad_lo_o` equals ofs[3:0] from the start strobe. `ad_hi_o | ad_lo_o` then equals (seg*16 + ofs) mod 2^20.
- R5: A start strobe loads `idx_o` with `ofs_i`.
- R6: An update-setup strobe followed by an update-commit strobe sets `idx_o` to (old idx + K) mod 2^16. K comes from `kon_sel_i`, sampled on the update-setup strobe: 0→0, 1→+1, 2→+2, 3→−1, 4→−2, 5→−3.
- R7: Codes 6 and 7 on `kon_sel_i` select K = 0, so the update leaves `idx_o` unchanged.
- R8: `ad_hi_o` and `ad_lo_o` change only on an address strobe. `idx_o` changes only on a start or update-commit strobe. Input changes at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| seg_i | input | 16 | Segment value |
| ofs_i | input | 16 | Offset value |
| kon_sel_i | input | 3 | Update constant selector |
| st_ts_i | input | 1 | Start strobe: load adder operands and the index register |
| st_t0_i | input | 1 | Address strobe: publish the address |
| st_t1_i | input | 1 | Update-setup strobe: load index and constant into the adder |
| st_t2_i | input | 1 | Update-commit strobe: write the sum to the index register |
| ad_lo_o | output | 4 | Low address nibble |
| ad_hi_o | output | 20 | Upper address, with bits 3:0 zero |
| idx_o | output | 16 | Index (offset) register |

## Verification
The bench builds the block with its defaults: a 16-bit segment, a 4-bit shift and a 3-bit selector. With these values every carry out of the 16-bit sum, and so every 2^20 wrap, can be reached from ordinary inputs; all-ones segment and offset give the worst case. The 3-bit selector makes all eight codes reachable, including the two unused ones. Index wrap is reached in both directions, from 0 with −3 and from 0xFFFF with +2.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [2:0] {
    K_ZERO = 3'd0,
    K_P1   = 3'd1,
    K_P2   = 3'd2,
    K_M1   = 3'd3,
    K_M2   = 3'd4,
    K_M3   = 3'd5
  } kon_code_e;
endpackage

// File: rtl/sag_kon_rom.sv
module sag_kon_rom #(
  parameter int SEL_W = 3,
  parameter int W     = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     val_o
);
  import sag_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  // Negative constants are formed in two's complement.
  always_comb begin
    val_o = '0;
    if (sel_i < SEL_W'(6)) begin
      case (kon_code_e'(sel_i[2:0]))
        K_P1:    val_o = ONE;
        K_P2:    val_o = TWO;
        K_M1:    val_o = '1;
        K_M2:    val_o = ~ONE;
        K_M3:    val_o = ~TWO;
        default: val_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sag_adder.sv
module sag_adder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] a_q, b_q, a_d, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (en_i) begin
      a_d = a_i;
      b_d = b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // Carry out of the top bit is dropped: the sum wraps.
  assign sum_o = a_q + b_q;

  p_opnd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/sag_nib.sv
module sag_nib #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          adv_i,
  input  logic [NW-1:0] nib_i,
  output logic [NW-1:0] mid_o,
  output logic [NW-1:0] nib_o
);
  logic [NW-1:0] mid_q, mid_d, out_q, out_d;

  always_comb begin
    mid_d = cap_i ? nib_i : mid_q;
    out_d = adv_i ? mid_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
      out_q <= '0;
    end else begin
      mid_q <= mid_d;
      out_q <= out_d;
    end
  end

  assign mid_o = mid_q;
  assign nib_o = out_q;

  p_nib_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (mid_q == $past(nib_i)));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEG_W-1:0]       seg_i,
  input  logic [SEG_W-1:0]       ofs_i,
  input  logic [SEL_W-1:0]       kon_sel_i,
  input  logic                   st_ts_i,
  input  logic                   st_t0_i,
  input  logic                   st_t1_i,
  input  logic                   st_t2_i,
  output logic [SHIFT-1:0]       ad_lo_o,
  output logic [SEG_W+SHIFT-1:0] ad_hi_o,
  output logic [SEG_W-1:0]       idx_o
);
  localparam int AD_W = SEG_W + SHIFT;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic [SEG_W-1:0] kon_val, opa_d, opb_d, sum;
  logic [SEG_W-1:0] idx_q, idx_d;
  logic [AD_W-1:0]  ad_q, ad_d;
  logic [SHIFT-1:0] nib_mid;
  logic             op_en;

  sag_kon_rom #(.SEL_W(SEL_W), .W(SEG_W)) u_rom (
    .sel_i (kon_sel_i),
    .val_o (kon_val)
  );

  // Operand select: segment arithmetic on start, index update otherwise.
  always_comb begin
    opa_d = idx_q;
    opb_d = kon_val;
    if (st_ts_i) begin
      opa_d = seg_i;
      opb_d = ofs_i >> SHIFT;
    end
  end
  assign op_en = st_ts_i | st_t1_i;

  sag_adder #(.W(SEG_W)) u_add (
    .clk   (clk),
    .rst_n (rst_ns),
    .en_i  (op_en),
    .a_i   (opa_d),
    .b_i   (opb_d),
    .sum_o (sum)
  );

  sag_nib #(.NW(SHIFT)) u_nib (
    .clk   (clk),
    .rst_n (rst_ns),
    .cap_i (st_ts_i),
    .adv_i (st_t0_i),
    .nib_i (ofs_i[SHIFT-1:0]),
    .mid_o (nib_mid),
    .nib_o (ad_lo_o)
  );

  always_comb begin
    ad_d  = st_t0_i ? {sum, {SHIFT{1'b0}}} : ad_q;
    idx_d = idx_q;
    if (st_ts_i)      idx_d = ofs_i;
    else if (st_t2_i) idx_d = sum;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ad_q  <= '0;
      idx_q <= '0;
    end else begin
      ad_q  <= ad_d;
      idx_q <= idx_d;
    end
  end

  assign ad_hi_o = ad_q;
  assign idx_o   = idx_q;

  p_addr_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    st_ts_i ##1 (st_t0_i && !st_ts_i) |=>
      ad_hi_o == {SEG_W'($past(seg_i, 2) + ($past(ofs_i, 2) >> SHIFT)), {SHIFT{1'b0}}});
  p_low_nib_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    st_t0_i |=> (ad_lo_o == $past(nib_mid)));
  p_idx_load_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    st_ts_i |=> (idx_o == $past(ofs_i)));
  p_upd_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_t1_i && !st_ts_i) ##1 (st_t2_i && !st_ts_i && !st_t1_i) |=>
      idx_o == SEG_W'($past(idx_o, 2) + $past(kon_val, 2)));
  p_ad_hold_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !st_t0_i |=> ($stable(ad_hi_o) && $stable(ad_lo_o)));
  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !(st_ts_i || st_t2_i) |=> $stable(idx_o));
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] seg_i = '0, ofs_i = '0;
  logic [2:0]  kon_sel_i = '0;
  logic        st_ts_i = 1'b0, st_t0_i = 1'b0, st_t1_i = 1'b0, st_t2_i = 1'b0;
  logic [3:0]  ad_lo_o;
  logic [19:0] ad_hi_o;
  logic [15:0] idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_idx = '0;

  always #2.5 clk = ~clk;

  seg_addr_gen u0 (.*);

  function automatic logic [15:0] kon(input logic [2:0] c);
    case (c)
      3'd1: return 16'd1;
      3'd2: return 16'd2;
      3'd3: return 16'hFFFF;
      3'd4: return 16'hFFFE;
      3'd5: return 16'hFFFD;
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({s, 4'h0} + {4'h0, o});
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_addr(input logic [15:0] s, input logic [15:0] o);
    @(negedge clk);
    seg_i = s; ofs_i = o; st_ts_i = 1'b1;
    @(negedge clk);
    st_ts_i = 1'b0; st_t0_i = 1'b1;
    seg_i = 16'($urandom); ofs_i = 16'($urandom);
    @(negedge clk);
    st_t0_i = 1'b0;
    exp_idx = o;
    chk("R2", {12'h0, ad_hi_o}, {12'h0, 16'(s + (o >> 4)), 4'h0});
    chk("R3", {28'h0, ad_hi_o[3:0]}, 32'h0);
    chk("R4", {28'h0, ad_lo_o}, {28'h0, o[3:0]});
    chk("R4", {12'h0, ad_hi_o | {16'h0, ad_lo_o}}, {12'h0, phys(s, o)});
    chk("R5", {16'h0, idx_o}, {16'h0, o});
  endtask

  task automatic do_upd(input logic [2:0] c, input string rq);
    @(negedge clk);
    kon_sel_i = c; st_t1_i = 1'b1;
    @(negedge clk);
    st_t1_i = 1'b0; st_t2_i = 1'b1; kon_sel_i = 3'($urandom);
    @(negedge clk);
    st_t2_i = 1'b0;
    exp_idx = exp_idx + kon(c);
    chk(rq, {16'h0, idx_o}, {16'h0, exp_idx});
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    chk("R1", {12'h0, ad_hi_o}, 32'h0);
    chk("R1", {28'h0, ad_lo_o}, 32'h0);
    chk("R1", {16'h0, idx_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {12'h0, ad_hi_o}, 32'h0);
    chk("R1", {16'h0, idx_o}, 32'h0);

    // Directed corners for R2/R4 wrap
    do_addr(16'hFFFF, 16'hFFFF);
    do_addr(16'h0000, 16'h0000);
    do_addr(16'hF000, 16'h1234);
    do_addr(16'hFFFF, 16'h0010);
    do_addr(16'h1234, 16'h000F);

    // R6 wrap both ways, all codes
    do_addr(16'h0, 16'h0000);
    do_upd(3'd5, "R6");
    do_addr(16'h0, 16'hFFFF);
    do_upd(3'd2, "R6");
    for (int c = 0; c < 6; c++) do_upd(3'(c), "R6");
    // R7 unused codes
    do_upd(3'd6, "R7");
    do_upd(3'd7, "R7");

    // R8: idle cycles with input churn leave outputs untouched
    do_addr(16'hABCD, 16'h5A5A);
    begin
      logic [19:0] h; logic [3:0] l; logic [15:0] x;
      h = ad_hi_o; l = ad_lo_o; x = idx_o;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        seg_i = 16'($urandom); ofs_i = 16'($urandom); kon_sel_i = 3'($urandom);
      end
      @(negedge clk);
      chk("R8", {12'h0, ad_hi_o}, {12'h0, h});
      chk("R8", {28'h0, ad_lo_o}, {28'h0, l});
      chk("R8", {16'h0, idx_o}, {16'h0, x});
      // an update leaves the published address alone
      do_upd(3'd1, "R6");
      chk("R8", {12'h0, ad_hi_o}, {12'h0, h});
    end

    // Random mix
    for (int n = 0; n < 80; n++) begin
      do_addr(16'($urandom), 16'($urandom));
      do_upd(3'($urandom), "R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule